// File: doc/BRIEF.md
# Counter-Compare PWM Channel

This block turns a shared, free-running 16-bit counter into one pulse-width-modulated output. Each channel holds a 16-bit compare value. Software loads that value one byte at a time through two strobes. The compare value is checked against the full counter value in every cycle. When the two are equal and the comparator is armed, an output flip-flop is set. The same flip-flop is cleared when the counter wraps from its largest value back to zero. This gives an output that is high for the upper part of each counter period.

Because the compare value is loaded as two separate bytes, a half-updated value could otherwise produce a spurious match. To prevent this, a write to the lower byte disarms the comparator. A write to the upper byte arms it again. The new 16-bit value therefore takes effect only once both halves are in place. With compare value C, the output is high for 65536 − C of every 65536 counter steps. A compare value of zero gives an output that stays high.

Top module: `pwm_channel`

## Requirements
- R1: While reset is held, `pwm_out` is 0, `armed` is 1 and `cmp_value` is 0x0000.
- R2: A cycle with `wr_lo` high and `wr_hi` low loads `wr_byte` into bits 7:0 of `cmp_value`, leaves bits 15:8 unchanged, and clears `armed`, all visible after that clock edge.
- R3: A cycle with `wr_hi` high loads `wr_byte` into bits 15:8 of `cmp_value` and sets `armed`. When `wr_lo` is also high in that cycle, bits 7:0 take the same byte and `armed` still ends up set.
- R4: When `armed` is 1 and `tb_count` equals `cmp_value`, `pwm_out` is 1 after the next clock edge.
- R5: When `tb_wrap` is high and no armed match is present in that cycle, `pwm_out` is 0 after the next clock edge.
- R6: An armed match and `tb_wrap` in the same cycle leave `pwm_out` at 1, so a compare value of 0x0000 keeps the output high.
- R7: While `armed` is 0, a counter value equal to `cmp_value` (or equal to the old full value) has no effect on `pwm_out`.
- R8: With no match and no wrap, `pwm_out` keeps its value. With neither write strobe, `cmp_value` and `armed` keep their values.
- R9: With the counter stepping through a full 65536-step period and compare value C, `pwm_out` is 1 in exactly 65536 − C of the cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 16 | Shared timebase counter value |
| tb_wrap | input | 1 | High in the cycle the timebase has just wrapped to 0x0000 |
| wr_lo | input | 1 | Write strobe for the low compare byte |
| wr_hi | input | 1 | Write strobe for the high compare byte |
| wr_byte | input | 8 | Byte written by either strobe |
| cmp_value | output | 16 | Current compare value |
| armed | output | 1 | Comparator enable |
| pwm_out | output | 1 | PWM output (flip-flop output) |

## Verification
A wrong armed flag shows up at the ports in two ways. A wrong compare byte shows up in `cmp_value` after the very next edge. It also shows up as an output rising at the wrong counter value, or not rising at all, within the same period. A stuck or mis-prioritised output flip-flop appears one cycle after a match or a wrap. Such a fault is most visible with a compare value of zero, where set and clear coincide. The half-written case is exercised by driving the counter to the old and new compare values while the comparator is disarmed. A full-period run then confirms the high-cycle count.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } pwm_act_e;
endpackage

// File: rtl/pwmc_cmp_reg.sv
module pwmc_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_byte,
  output logic [CNT_W-1:0]   cmp_q,
  output logic               armed_q
);
  localparam int HALF_W = CNT_W / 2;
  localparam int LANES  = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = (g == 0) ? wr_lo : wr_hi;
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[g*HALF_W +: HALF_W] <= '0;
      end else if (lane_we) begin
        cmp_q[g*HALF_W +: HALF_W] <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
    end else if (wr_hi) begin
      armed_q <= 1'b1;
    end else if (wr_lo) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmc_match.sv
module pwmc_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic             armed,
  output logic             hit
);
  logic eq;
  always_comb begin
    eq  = (count == cmp);
    hit = eq & armed;
  end
endmodule

// File: rtl/pwmc_latch.sv
module pwmc_latch
  import pwmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wrap,
  output logic q
);
  pwm_act_e act;

  always_comb begin
    if (hit) begin
      act = ACT_SET;
    end else if (wrap) begin
      act = ACT_CLR;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (act)
        ACT_SET: q <= 1'b1;
        ACT_CLR: q <= 1'b0;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   tb_count,
  input  logic               tb_wrap,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_byte,
  output logic [CNT_W-1:0]   cmp_value,
  output logic               armed,
  output logic               pwm_out
);
  logic hit;

  pwmc_cmp_reg #(.CNT_W(CNT_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_byte (wr_byte),
    .cmp_q   (cmp_value),
    .armed_q (armed)
  );

  pwmc_match #(.CNT_W(CNT_W)) u_match (
    .count (tb_count),
    .cmp   (cmp_value),
    .armed (armed),
    .hit   (hit)
  );

  pwmc_latch u_latch (
    .clk  (clk),
    .rst  (rst),
    .hit  (hit),
    .wrap (tb_wrap),
    .q    (pwm_out)
  );
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [CNT_W-1:0]   tb_count,
  input logic               tb_wrap,
  input logic               wr_lo,
  input logic               wr_hi,
  input logic [CNT_W/2-1:0] wr_byte,
  input logic [CNT_W-1:0]   cmp_value,
  input logic               armed,
  input logic               pwm_out
);
  localparam int HALF_W = CNT_W / 2;
  logic started;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b1;
  end

  assign live = (started === 1'b1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!pwm_out && armed && cmp_value == '0)); // R1
  AST_LO_DISARMS: assert property (@(posedge clk) disable iff (rst || !live)
    (wr_lo && !wr_hi) |=> (!armed && cmp_value[HALF_W-1:0] == $past(wr_byte)
                           && $stable(cmp_value[CNT_W-1:HALF_W]))); // R2
  AST_HI_ARMS: assert property (@(posedge clk) disable iff (rst || !live)
    wr_hi |=> (armed && cmp_value[CNT_W-1:HALF_W] == $past(wr_byte))); // R3
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst || !live)
    (armed && tb_count == cmp_value) |=> pwm_out); // R4
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (rst || !live)
    (tb_wrap && !(armed && tb_count == cmp_value)) |=> !pwm_out); // R5
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst || !live)
    (!armed && !tb_wrap) |=> $stable(pwm_out)); // R7
  AST_REG_HOLDS: assert property (@(posedge clk) disable iff (rst || !live)
    (!wr_lo && !wr_hi) |=> ($stable(cmp_value) && $stable(armed))); // R8
endmodule

bind pwm_channel pwmc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tb_count  (tb_count),
  .tb_wrap   (tb_wrap),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_byte   (wr_byte),
  .cmp_value (cmp_value),
  .armed     (armed),
  .pwm_out   (pwm_out)
);

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tb_count = 16'h0100;
  logic        tb_wrap = 1'b0;
  logic        wr_lo = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic [15:0] cmp_value;
  logic        armed;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [15:0] m_cmp = 16'h0000;
  logic        m_arm = 1'b1;
  logic        m_pwm = 1'b0;

  always #10 clk = ~clk;

  pwm_channel dut (
    .clk(clk), .rst(rst), .tb_count(tb_count), .tb_wrap(tb_wrap),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_byte(wr_byte),
    .cmp_value(cmp_value), .armed(armed), .pwm_out(pwm_out)
  );

  // Behavioural reference, evaluated from the requirement text
  always @(posedge clk) begin
    bit hit;
    if (rst) begin
      m_cmp = 16'h0000; m_arm = 1'b1; m_pwm = 1'b0;
    end else begin
      hit = m_arm && (tb_count == m_cmp);
      if (hit) m_pwm = 1'b1;
      else if (tb_wrap) m_pwm = 1'b0;
      if (wr_lo) m_cmp[7:0] = wr_byte;
      if (wr_hi) m_cmp[15:8] = wr_byte;
      if (wr_hi) m_arm = 1'b1;
      else if (wr_lo) m_arm = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwm_out !== m_pwm || armed !== m_arm || cmp_value !== m_cmp) begin
        errors++;
        $display("FAIL model R4/R5/R2/R3 cyc %0d: pwm %b arm %b cmp %h expected pwm %b arm %b cmp %h",
                 cycles, pwm_out, armed, cmp_value, m_pwm, m_arm, m_cmp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] cnt, logic wrap, logic lo, logic hi, logic [7:0] d);
    tb_count = cnt; tb_wrap = wrap; wr_lo = lo; wr_hi = hi; wr_byte = d;
    @(posedge clk);
    @(negedge clk);
    tb_wrap = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  initial begin
    int high;
    repeat (3) @(negedge clk);
    chk("R1 pwm", {15'd0, pwm_out}, 16'h0000);
    chk("R1 armed", {15'd0, armed}, 16'h0001);
    chk("R1 cmp", cmp_value, 16'h0000);
    rst = 1'b0;

    step(16'h0100, 0, 0, 0, 8'h00);
    chk("R8 hold low", {15'd0, pwm_out}, 16'h0000);
    step(16'h0100, 0, 1, 0, 8'h34);
    chk("R2 armed", {15'd0, armed}, 16'h0000);
    chk("R2 cmp", cmp_value, 16'h0034);
    step(16'h0034, 0, 0, 0, 8'h00);
    chk("R7 half value no set", {15'd0, pwm_out}, 16'h0000);
    step(16'h0200, 0, 0, 1, 8'h12);
    chk("R3 armed", {15'd0, armed}, 16'h0001);
    chk("R3 cmp", cmp_value, 16'h1234);
    step(16'h1234, 0, 0, 0, 8'h00);
    chk("R4 match sets", {15'd0, pwm_out}, 16'h0001);
    step(16'h1235, 0, 0, 0, 8'h00);
    chk("R8 hold high", {15'd0, pwm_out}, 16'h0001);
    step(16'h0000, 1, 0, 0, 8'h00);
    chk("R5 wrap clears", {15'd0, pwm_out}, 16'h0000);
    step(16'h0300, 0, 1, 0, 8'h56);
    chk("R2 cmp second", cmp_value, 16'h1256);
    step(16'h1256, 0, 0, 0, 8'h00);
    chk("R7 new value disarmed", {15'd0, pwm_out}, 16'h0000);
    step(16'h1234, 0, 0, 0, 8'h00);
    chk("R7 old value disarmed", {15'd0, pwm_out}, 16'h0000);
    step(16'h0400, 0, 0, 1, 8'h12);
    step(16'h1256, 0, 0, 0, 8'h00);
    chk("R4 rearmed match", {15'd0, pwm_out}, 16'h0001);
    step(16'h0000, 1, 0, 0, 8'h00);
    chk("R5 wrap clears again", {15'd0, pwm_out}, 16'h0000);
    step(16'h0500, 0, 1, 1, 8'h00);
    chk("R3 both strobes cmp", cmp_value, 16'h0000);
    chk("R3 both strobes armed", {15'd0, armed}, 16'h0001);
    step(16'h0000, 1, 0, 0, 8'h00);
    chk("R6 match beats wrap", {15'd0, pwm_out}, 16'h0001);

    // Full period with compare 0xC000
    step(16'h0600, 0, 1, 0, 8'h00);
    step(16'h0700, 0, 0, 1, 8'hC0);
    step(16'hFFFF, 0, 0, 0, 8'h00);
    high = 0;
    for (int i = 0; i < 65536; i++) begin
      step(i[15:0], (i == 0), 0, 0, 8'h00);
      if (pwm_out) high++;
    end
    chk("R9 high cycles", high[15:0], 16'h4000);

    // Mixed random traffic, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] c;
      int r;
      r = $urandom_range(0, 9);
      c = (r < 3) ? m_cmp : (r == 3) ? {m_cmp[15:8], ~m_cmp[7:0]} : 16'($urandom);
      step(c, ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 5) == 0), 8'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule